// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block turns one interprocessor interrupt command into a set of receiving units. The command arrives as a 64-bit word pair with a one-cycle strobe and the index of the sending unit. Each of the `NUM_UNITS` local units describes itself through static configuration inputs: an 8-bit physical ID, an 8-bit logical ID, a 4-bit logical-format code, and present and enabled flags. The resolver compares every unit against the command in parallel. It can address units by shorthand, by physical ID or by logical ID, and logical addressing comes in flat or cluster form.

For most delivery modes the registered result appears one cycle after the strobe: a mask of receiving units, plus the vector, delivery mode, level and trigger flags. The lowest-priority mode is different. It does not compare task priorities. It stores the match bitmap and walks a round-robin pointer one unit per cycle until it lands on a matched unit that is present and enabled. That unit alone receives the interrupt, and `busy` stays high for the whole walk.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With shorthand 0 (low word bits [19:18]) and physical addressing (low bit 11 = 0), a present unit matches when the destination (high word bits [31:24]) equals its physical ID, or when the destination is 0xFF.
- R2: With logical addressing (low bit 11 = 1), a unit whose format code is 4'hF (flat) matches when its logical ID ANDed with the destination is nonzero.
- R3: A unit whose format code is 4'h0 (cluster) matches when its logical-ID upper nibble equals the destination's upper nibble and the two lower nibbles share a set bit. A unit with any other format code never matches a logical destination.
- R4: Shorthand 1 selects only the sender, 2 selects every unit, and 3 selects every unit except the sender. The destination field is ignored for these codes, and absent units are never selected.
- R5: For any delivery mode other than lowest priority (mode bits [10:8] = 3'b001), the cycle after an accepted strobe shows `dlv_valid` with the match mask and these fields: vector from bits [7:0], the mode, level from bit 14 and trigger from bit 15.
- R6: An INIT command (mode 3'b101) that has trigger = 1 (level) and level = 0 produces no delivery. INIT with the level bit set is delivered normally.
- R7: A lowest-priority command keeps `busy` high while it tests candidates one per cycle. The first candidate is the unit after the previously chosen one, and the walk wraps around. Unmatched, absent and disabled units are skipped. Exactly one unit is delivered, and it becomes the saved pointer.
- R8: After reset the saved pointer is the last unit, so the first lowest-priority search picks unit 0 if it qualifies.
- R9: If no candidate qualifies, the walk ends back at the saved pointer. `busy` clears, no delivery is made, and the pointer is left unchanged.
- R10: A strobe that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_lo | input | 32 | Command low word |
| cmd_hi | input | 32 | Command high word (destination in [31:24]) |
| cmd_src | input | IDX_W | Index of the sending unit |
| unit_present | input | NUM_UNITS | Unit exists |
| unit_enabled | input | NUM_UNITS | Unit may accept lowest-priority interrupts |
| unit_phys_id | input | NUM_UNITS*8 | Physical IDs, unit i in bits [8i+7:8i] |
| unit_log_id | input | NUM_UNITS*8 | Logical IDs, unit i in bits [8i+7:8i] |
| unit_fmt | input | NUM_UNITS*4 | Logical format codes, unit i in bits [4i+3:4i] |
| busy | output | 1 | Lowest-priority search in progress |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_mask | output | NUM_UNITS | Receiving units |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivered mode |
| dlv_level | output | 1 | Delivered level flag |
| dlv_trig | output | 1 | Delivered trigger flag |

## Verification
The hardest case to reach from the ports is a round-robin walk that finds nothing and then leaves the pointer where it was. This only shows up in the choice made by the next search. The bench first steers the pointer to a known unit through a series of lowest-priority commands. It then clears every enable, issues a search and checks that it ends without a delivery. Finally it re-enables all units and confirms that the next pick is the unit right after the earlier one. A second hard case is a strobe during a long walk. The bench enables a single unit that lies far behind the pointer, so the walk lasts several cycles, and injects a fixed command in the middle of it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [2:0] MODE_LOWEST = 3'b001;
    localparam logic [2:0] MODE_INIT   = 3'b101;
    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST  = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       logical;
        logic       level;
        logic       trig;
        shorthand_e shorthand;
        logic [7:0] dest;
    } ipi_cmd_t;

    function automatic ipi_cmd_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
        ipi_cmd_t c;
        c.vector    = lo[7:0];
        c.mode      = lo[10:8];
        c.logical   = lo[11];
        c.level     = lo[14];
        c.trig      = lo[15];
        c.shorthand = shorthand_e'(lo[19:18]);
        c.dest      = hi[31:24];
        return c;
    endfunction

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
    import ipi_pkg::*;
#(
    parameter int UNIT  = 0,
    parameter int IDX_W = 3
) (
    input  logic [7:0]       dest,
    input  logic             logical,
    input  shorthand_e       shorthand,
    input  logic [IDX_W-1:0] src,
    input  logic [7:0]       phys_id,
    input  logic [7:0]       log_id,
    input  logic [3:0]       fmt,
    input  logic             present,
    output logic             hit
);

    logic addr_hit;
    logic is_self;
    logic sel;

    always_comb begin
        if (!logical) begin
            addr_hit = (dest == DEST_BCAST) || (dest == phys_id);
        end else begin
            case (fmt)
                FMT_FLAT:    addr_hit = |(log_id & dest);
                FMT_CLUSTER: addr_hit = (log_id[7:4] == dest[7:4]) && (|(log_id[3:0] & dest[3:0]));
                default:     addr_hit = 1'b0;
            endcase
        end
        is_self = (src == IDX_W'(UNIT));
        case (shorthand)
            SH_DEST:   sel = addr_hit;
            SH_SELF:   sel = is_self;
            SH_ALL:    sel = 1'b1;
            SH_OTHERS: sel = !is_self;
            default:   sel = 1'b0;
        endcase
        hit = present && sel;
    end

endmodule

// File: rtl/ipi_rr_scan.sv
module ipi_rr_scan #(
    parameter int NUM_UNITS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [IDX_W-1:0]     cand,
    input  logic [IDX_W-1:0]     ptr,
    input  logic [NUM_UNITS-1:0] bitmap,
    input  logic [NUM_UNITS-1:0] enabled,
    output logic                 take,
    output logic                 last,
    output logic [IDX_W-1:0]     cand_nxt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UNITS - 1);

    always_comb begin
        take     = bitmap[cand] && enabled[cand];
        last     = (cand == ptr);
        cand_nxt = (cand == LAST_IDX) ? '0 : cand + 1'b1;
    end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
    import ipi_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [31:0]            cmd_lo,
    input  logic [31:0]            cmd_hi,
    input  logic [IDX_W-1:0]       cmd_src,
    input  logic [NUM_UNITS-1:0]   unit_present,
    input  logic [NUM_UNITS-1:0]   unit_enabled,
    input  logic [NUM_UNITS*8-1:0] unit_phys_id,
    input  logic [NUM_UNITS*8-1:0] unit_log_id,
    input  logic [NUM_UNITS*4-1:0] unit_fmt,
    output logic                   busy,
    output logic                   dlv_valid,
    output logic [NUM_UNITS-1:0]   dlv_mask,
    output logic [7:0]             dlv_vector,
    output logic [2:0]             dlv_mode,
    output logic                   dlv_level,
    output logic                   dlv_trig
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UNITS - 1);

    typedef struct packed {
        logic                 busy;
        logic [NUM_UNITS-1:0] bitmap;
        logic [IDX_W-1:0]     ptr;
        logic [IDX_W-1:0]     cand;
        logic                 out_valid;
        logic [NUM_UNITS-1:0] out_mask;
        logic [7:0]           vec;
        logic [2:0]           mode;
        logic                 lvl;
        logic                 trig;
    } state_t;

    state_t st_d, st_q;

    ipi_cmd_t             cmd;
    logic [NUM_UNITS-1:0] hits;
    logic                 rr_take;
    logic                 rr_last;
    logic [IDX_W-1:0]     rr_nxt;
    logic                 init_drop;

    assign cmd = decode_cmd(cmd_lo, cmd_hi);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ipi_unit_match #(
            .UNIT  (u),
            .IDX_W (IDX_W)
        ) match_i (
            .dest      (cmd.dest),
            .logical   (cmd.logical),
            .shorthand (cmd.shorthand),
            .src       (cmd_src),
            .phys_id   (unit_phys_id[u*8 +: 8]),
            .log_id    (unit_log_id[u*8 +: 8]),
            .fmt       (unit_fmt[u*4 +: 4]),
            .present   (unit_present[u]),
            .hit       (hits[u])
        );
    end

    ipi_rr_scan #(
        .NUM_UNITS (NUM_UNITS),
        .IDX_W     (IDX_W)
    ) scan_i (
        .cand     (st_q.cand),
        .ptr      (st_q.ptr),
        .bitmap   (st_q.bitmap),
        .enabled  (unit_enabled),
        .take     (rr_take),
        .last     (rr_last),
        .cand_nxt (rr_nxt)
    );

    assign init_drop = (cmd.mode == MODE_INIT) && cmd.trig && !cmd.level;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (st_q.busy) begin
            if (rr_take) begin
                st_d.out_valid           = 1'b1;
                st_d.out_mask            = '0;
                st_d.out_mask[st_q.cand] = 1'b1;
                st_d.ptr                 = st_q.cand;
                st_d.busy                = 1'b0;
            end else if (rr_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cand = rr_nxt;
            end
        end else if (cmd_valid) begin
            if (cmd.mode == MODE_LOWEST) begin
                st_d.busy   = 1'b1;
                st_d.bitmap = hits;
                st_d.cand   = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
                st_d.vec    = cmd.vector;
                st_d.mode   = cmd.mode;
                st_d.lvl    = cmd.level;
                st_d.trig   = cmd.trig;
            end else if (!init_drop) begin
                st_d.out_valid = 1'b1;
                st_d.out_mask  = hits;
                st_d.vec       = cmd.vector;
                st_d.mode      = cmd.mode;
                st_d.lvl       = cmd.level;
                st_d.trig      = cmd.trig;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= LAST_IDX;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign dlv_valid  = st_q.out_valid;
    assign dlv_mask   = st_q.out_mask;
    assign dlv_vector = st_q.vec;
    assign dlv_mode   = st_q.mode;
    assign dlv_level  = st_q.lvl;
    assign dlv_trig   = st_q.trig;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
    parameter int NUM_UNITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [31:0]          cmd_lo,
    input logic                 busy,
    input logic                 dlv_valid,
    input logic [NUM_UNITS-1:0] dlv_mask,
    input logic [2:0]           dlv_mode
);

    logic lowest_cmd;
    logic init_drop_cmd;

    assign lowest_cmd    = (cmd_lo[10:8] == 3'b001);
    assign init_drop_cmd = (cmd_lo[10:8] == 3'b101) && cmd_lo[15] && !cmd_lo[14];

    assert_lowest_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_mode == 3'b001) |-> ($countones(dlv_mask) == 1));

    assert_deliver_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> !busy);

    assert_lowest_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && lowest_cmd) |=> busy);

    assert_direct_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !lowest_cmd && !init_drop_cmd) |=> dlv_valid);

    assert_init_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && init_drop_cmd) |=> !dlv_valid);

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (!dlv_valid || dlv_mode == 3'b001));

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_lo    (cmd_lo),
    .busy      (busy),
    .dlv_valid (dlv_valid),
    .dlv_mask  (dlv_mask),
    .dlv_mode  (dlv_mode)
);

// File: tb/ipi_dest_resolver_tb_top.sv
`timescale 1ns/1ps
module ipi_dest_resolver_tb_top;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam int NV = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [31:0]     cmd_lo = '0;
    logic [31:0]     cmd_hi = '0;
    logic [IW-1:0]   cmd_src = '0;
    logic [N-1:0]    unit_present = '1;
    logic [N-1:0]    unit_enabled = '1;
    logic [N*8-1:0]  unit_phys_id;
    logic [N*8-1:0]  unit_log_id;
    logic [N*4-1:0]  unit_fmt;
    logic            busy, dlv_valid, dlv_level, dlv_trig;
    logic [N-1:0]    dlv_mask;
    logic [7:0]      dlv_vector;
    logic [2:0]      dlv_mode;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ipi_dest_resolver #(.NUM_UNITS(N)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_lo       (cmd_lo),
        .cmd_hi       (cmd_hi),
        .cmd_src      (cmd_src),
        .unit_present (unit_present),
        .unit_enabled (unit_enabled),
        .unit_phys_id (unit_phys_id),
        .unit_log_id  (unit_log_id),
        .unit_fmt     (unit_fmt),
        .busy         (busy),
        .dlv_valid    (dlv_valid),
        .dlv_mask     (dlv_mask),
        .dlv_vector   (dlv_vector),
        .dlv_mode     (dlv_mode),
        .dlv_level    (dlv_level),
        .dlv_trig     (dlv_trig)
    );

    // Direct-delivery vectors: low word, high word, sender, expected mask, requirement
    localparam logic [31:0] V_LO [NV] = '{
        32'h0000_0030, 32'h0000_0031, 32'h0000_0032,   // R1
        32'h0000_0840,                                 // R2
        32'h0000_0841, 32'h0000_0842,                  // R3
        32'h0004_0050, 32'h0008_0051, 32'h000C_0052,   // R4
        32'h0000_C060                                  // R5
    };
    localparam logic [31:0] V_HI [NV] = '{
        32'h1300_0000, 32'hFF00_0000, 32'h4200_0000,
        32'h0500_0000,
        32'h2300_0000, 32'h2000_0000,
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
        32'h1000_0000
    };
    localparam int V_SRC [NV] = '{0, 0, 0, 0, 0, 0, 5, 2, 2, 0};
    localparam logic [7:0] V_EXP [NV] = '{
        8'h08, 8'hFF, 8'h00, 8'h05, 8'h33, 8'h00, 8'h20, 8'hFF, 8'hFB, 8'h01
    };
    localparam int V_REQ [NV] = '{1, 1, 1, 2, 3, 3, 4, 4, 4, 5};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [31:0] lo, input logic [31:0] hi, input int src);
        @(negedge clk);
        cmd_lo    = lo;
        cmd_hi    = hi;
        cmd_src   = IW'(src);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // waits for the end of a lowest-priority walk; returns delivered flag and mask
    task automatic walk(output logic got, output logic [N-1:0] m);
        got = 1'b0;
        m   = '0;
        for (int k = 0; k < 3 * N; k++) begin
            if (dlv_valid) begin
                got = 1'b1;
                m   = dlv_mask;
                break;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic lowest_pick(input string req, input logic [31:0] lo, input logic [31:0] hi,
                               input logic [N-1:0] exp);
        logic g;
        logic [N-1:0] m;
        strobe(lo, hi, 0);
        check(req, {31'd0, busy}, 32'd1);
        walk(g, m);
        check(req, {31'd0, g}, 32'd1);
        check(req, {24'd0, m}, {24'd0, exp});
        check(req, {29'd0, dlv_mode}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            unit_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
            if (i < 4) begin
                unit_log_id[i*8 +: 8] = 8'(1 << i);
                unit_fmt[i*4 +: 4]    = 4'hF;
            end else begin
                unit_log_id[i*8 +: 8] = {4'h2, 4'(1 << (i - 4))};
                unit_fmt[i*4 +: 4]    = 4'h0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic g;
        logic [N-1:0] m;
        int pulses;
        logic [N-1:0] seen;
        logic [2:0]   seen_mode;

        repeat (3) @(negedge clk);
        check("R5 reset valid", {31'd0, dlv_valid}, 32'd0);
        check("R7 reset busy", {31'd0, busy}, 32'd0);
        check("R5 reset mask", {24'd0, dlv_mask}, 32'd0);
        rst_n = 1'b1;

        // table walk: R1..R5
        for (int v = 0; v < NV; v++) begin
            strobe(V_LO[v], V_HI[v], V_SRC[v]);
            check($sformatf("R%0d vec%0d valid", V_REQ[v], v), {31'd0, dlv_valid}, 32'd1);
            check($sformatf("R%0d vec%0d mask", V_REQ[v], v), {24'd0, dlv_mask}, {24'd0, V_EXP[v]});
            check($sformatf("R%0d vec%0d vector", V_REQ[v], v), {24'd0, dlv_vector}, {24'd0, V_LO[v][7:0]});
        end
        // R5 fields of last vector: level 1, trigger 1, mode 0
        check("R5 level", {31'd0, dlv_level}, 32'd1);
        check("R5 trig", {31'd0, dlv_trig}, 32'd1);
        check("R5 mode", {29'd0, dlv_mode}, 32'd0);

        // R3 invalid format on unit 7: only flat unit 3 matches 0x28
        unit_fmt[7*4 +: 4] = 4'h5;
        strobe(32'h0000_0843, 32'h2800_0000, 0);
        check("R3 bad format", {24'd0, dlv_mask}, 32'h08);
        unit_fmt[7*4 +: 4] = 4'h0;

        // R4 absent unit excluded from broadcast shorthand
        unit_present = 8'h7F;
        strobe(32'h0008_0053, 32'h0, 0);
        check("R4 absent", {24'd0, dlv_mask}, 32'h7F);
        unit_present = 8'hFF;

        // R6 INIT with level trigger, deasserted: dropped
        strobe(32'h0000_8500, 32'h1000_0000, 0);
        check("R6 init deassert", {31'd0, dlv_valid}, 32'd0);
        strobe(32'h0000_C500, 32'h1000_0000, 0);
        check("R6 init assert valid", {31'd0, dlv_valid}, 32'd1);
        check("R6 init assert mask", {24'd0, dlv_mask}, 32'h01);

        // R8 first lowest-priority pick after reset is unit 0
        lowest_pick("R8", 32'h0008_0170, 32'h0, 8'h01);
        lowest_pick("R7 next", 32'h0008_0171, 32'h0, 8'h02);
        unit_enabled = 8'hE7;
        lowest_pick("R7 step", 32'h0008_0172, 32'h0, 8'h04);
        lowest_pick("R7 skip disabled", 32'h0008_0173, 32'h0, 8'h20);
        unit_enabled = 8'hFF;
        // physical dest 0x11 -> only unit 1 matched; walk 6,7,0,1
        lowest_pick("R7 skip unmatched", 32'h0000_0174, 32'h1100_0000, 8'h02);

        // R9 nothing enabled: no delivery, pointer stays at unit 1
        unit_enabled = 8'h00;
        strobe(32'h0008_0175, 32'h0, 0);
        walk(g, m);
        check("R9 no delivery", {31'd0, g}, 32'd0);
        check("R9 busy cleared", {31'd0, busy}, 32'd0);
        unit_enabled = 8'hFF;
        lowest_pick("R9 pointer kept", 32'h0008_0176, 32'h0, 8'h04);

        // R10 strobe during busy walk is ignored (only unit 0 enabled, pointer at 2)
        unit_enabled = 8'h01;
        strobe(32'h0008_0177, 32'h0, 0);
        check("R10 busy", {31'd0, busy}, 32'd1);
        cmd_lo    = 32'h0000_0030;
        cmd_hi    = 32'h1300_0000;
        cmd_valid = 1'b1;
        pulses    = 0;
        seen      = '0;
        seen_mode = '0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (dlv_valid) begin
                pulses++;
                seen      = dlv_mask;
                seen_mode = dlv_mode;
            end
        end
        check("R10 one delivery", pulses, 32'd1);
        check("R10 mask", {24'd0, seen}, 32'h01);
        check("R10 mode", {29'd0, seen_mode}, 32'd1);
        unit_enabled = 8'hFF;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule